// File: doc/BRIEF.md
# Framed Serial Register Write Receiver

This block is the device-side receiver for the write port of a synchronous serial interface on a converter-style peripheral. An external master drives a serial clock, a data line, an active-low frame sync and a target-select line. All four are brought into the system clock domain through two-flop synchronisers. A data bit is taken on each detected rising edge of the synchronised serial clock, but only while the frame sync is asserted. Bits arrive most significant first.

A word is exactly `WORD_W` bits long (24 by default). When the last bit arrives, the word is committed to one of two parallel-output registers: the control register when the select line is low, or the calibration register when it is high. The master may release the frame sync partway through a word and assert it again later. The bits received so far and the bit position are kept across that pause. The select line must stay constant for the whole word. If it changes while a word is partly received, the partial word is dropped, the bit count returns to zero, and a sticky error flag is raised.

The controller is a four-state machine:
- **ST_IDLE**: no bits held.
- **ST_SHIFT**: a word is in progress and the frame sync is asserted.
- **ST_PAUSE**: a word is in progress and the frame sync is released.
- **ST_COMMIT**: a one-cycle write.

The named transitions are:
- *start*: IDLE to SHIFT, on the first bit.
- *suspend*: SHIFT to PAUSE, when the sync is released.
- *resume*: PAUSE to SHIFT, when the sync is asserted again.
- *complete*: SHIFT or PAUSE to COMMIT, on the last bit.
- *abort*: SHIFT or PAUSE to IDLE, when the select line changes.
- *retire*: COMMIT to IDLE.

Top module: `fwr_receiver`

## Requirements
- R1: After reset, `ctrl_reg` and `cal_reg` are zero, `wr_stb` is 0 and `sel_err` is 0.
- R2: A word is assembled from exactly `WORD_W` bits, first bit in the most significant position. `wr_data` carries the full word while `wr_stb` is high.
- R3: A completed word sent with `a0` = 0 is loaded into `ctrl_reg` one cycle after the strobe. `cal_reg` is unchanged.
- R4: A completed word sent with `a0` = 1 is loaded into `cal_reg` one cycle after the strobe. `ctrl_reg` is unchanged.
- R5: Serial clock pulses while `tfs_n` is high capture nothing and do not advance the bit position.
- R6: Releasing `tfs_n` mid-word and asserting it again resumes at the saved bit position, with no bits lost.
- R7: A word with fewer than `WORD_W` bits never raises `wr_stb` and never changes either register.
- R8: A change of `a0` while a word is partly received discards the partial word and resets the bit count. The next full word is then committed correctly.
- R9: Each completed word raises `wr_stb` for exactly one system cycle. `wr_sel` equals the `a0` level used for that word (0 = control, 1 = calibration).
- R10: `sel_err` is set by a select change mid-word (R8) and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles low |
| sdata | input | 1 | Serial data, valid before the serial clock rises |
| tfs_n | input | 1 | Active-low frame sync |
| a0 | input | 1 | Target select: 0 control, 1 calibration |
| ctrl_reg | output | WORD_W | Control register contents |
| cal_reg | output | WORD_W | Calibration register contents |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_sel | output | 1 | Target of the current strobe |
| wr_data | output | WORD_W | Assembled word, valid during the strobe |
| sel_err | output | 1 | Sticky select-change error |

## Verification
The assertions check several properties on every cycle:
- The strobe lasts a single cycle.
- The error flag is sticky.
- Each register changes only in the cycle after a strobe aimed at it.
- The register then holds the word presented on `wr_data`.

Other behaviours can only be shown by the bench's scenarios, because they depend on the serial bit stream over many cycles:
- Bit ordering.
- Pause and resume at every bit position.
- Clock pulses ignored while the sync is released.
- Refusal to commit a short word.
- Recovery after a select change.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_PAUSE  = 2'd2,
        ST_COMMIT = 2'd3
    } fwr_state_e;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_CAL  = 1'b1;
endpackage

// File: rtl/fwr_sync.sv
module fwr_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/fwr_shift.sv
module fwr_shift #(
    parameter int WORD_W = 24,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cnt_clr,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  bit_cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word    <= '0;
            bit_cnt <= '0;
        end else if (cnt_clr) begin
            word    <= '0;
            bit_cnt <= '0;
        end else if (cap_en) begin
            word    <= {word[WORD_W-2:0], din};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fwr_fsm.sv
module fwr_fsm
    import fwr_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             tfs_act,
    input  logic             a0_s,
    input  logic [CNT_W-1:0] bit_cnt,
    output logic             cap_en,
    output logic             cnt_clr,
    output logic             wr_stb,
    output logic             wr_sel,
    output logic             sel_err
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    fwr_state_e st, st_nx;
    logic       a0_lat;
    logic       busy, mism, take, last;

    assign busy = (st == ST_SHIFT) || (st == ST_PAUSE);
    assign mism = busy && (a0_s != a0_lat);
    assign take = sclk_rise && tfs_act && !mism && (st != ST_COMMIT);
    assign last = take && (bit_cnt == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // select latch and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a0_lat  <= SEL_CTRL;
            sel_err <= 1'b0;
        end else begin
            if (st == ST_IDLE && take) begin
                a0_lat <= a0_s;
            end
            if (mism) begin
                sel_err <= 1'b1;
            end
        end
    end

    // transitions: start, suspend, resume, complete, abort, retire
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (take) begin
                    st_nx = last ? ST_COMMIT : ST_SHIFT;
                end
            end
            ST_SHIFT, ST_PAUSE: begin
                if (mism) begin
                    st_nx = ST_IDLE;
                end else if (last) begin
                    st_nx = ST_COMMIT;
                end else if (!tfs_act) begin
                    st_nx = ST_PAUSE;
                end else begin
                    st_nx = ST_SHIFT;
                end
            end
            ST_COMMIT: st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cap_en  = take;
        cnt_clr = (st == ST_COMMIT) || mism;
        wr_stb  = (st == ST_COMMIT);
        wr_sel  = a0_lat;
    end
endmodule

// File: rtl/fwr_regs.sv
module fwr_regs
    import fwr_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] cal_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cal_q  <= '0;
        end else if (we) begin
            if (sel == SEL_CAL) begin
                cal_q <= din;
            end else begin
                ctrl_q <= din;
            end
        end
    end
endmodule

// File: rtl/fwr_receiver.sv
module fwr_receiver #(
    parameter int WORD_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              tfs_n,
    input  logic              a0,
    output logic [WORD_W-1:0] ctrl_reg,
    output logic [WORD_W-1:0] cal_reg,
    output logic              wr_stb,
    output logic              wr_sel,
    output logic [WORD_W-1:0] wr_data,
    output logic              sel_err
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int PIN_N = 4;
    // pin order {sclk, sdata, tfs_n, a0}; tfs_n resets inactive (high)
    localparam logic [PIN_N-1:0] PIN_RST = 4'b0010;

    logic [PIN_N-1:0] pins_s;
    logic             s_sclk, s_sdata, s_tfs_n, s_a0;
    logic             sclk_d;
    logic             sclk_rise;
    logic             cap_en, cnt_clr;
    logic [CNT_W-1:0] bit_cnt;

    fwr_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk, sdata, tfs_n, a0}),
        .q    (pins_s)
    );

    assign {s_sclk, s_sdata, s_tfs_n, s_a0} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= s_sclk;
        end
    end

    assign sclk_rise = s_sclk && !sclk_d;

    fwr_fsm #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_rise(sclk_rise),
        .tfs_act  (!s_tfs_n),
        .a0_s     (s_a0),
        .bit_cnt  (bit_cnt),
        .cap_en   (cap_en),
        .cnt_clr  (cnt_clr),
        .wr_stb   (wr_stb),
        .wr_sel   (wr_sel),
        .sel_err  (sel_err)
    );

    fwr_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .cnt_clr(cnt_clr),
        .din    (s_sdata),
        .word   (wr_data),
        .bit_cnt(bit_cnt)
    );

    fwr_regs #(.WORD_W(WORD_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_stb),
        .sel   (wr_sel),
        .din   (wr_data),
        .ctrl_q(ctrl_reg),
        .cal_q (cal_reg)
    );
endmodule

// File: rtl/fwr_receiver_chk.sv
module fwr_receiver_chk #(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] ctrl_reg,
    input logic [WORD_W-1:0] cal_reg,
    input logic              wr_stb,
    input logic              wr_sel,
    input logic [WORD_W-1:0] wr_data,
    input logic              sel_err
);
    p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |=> sel_err);

    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && !wr_sel) |=> $stable(ctrl_reg));

    p_cal_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_sel) |=> $stable(cal_reg));

    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_sel) |=> (ctrl_reg == $past(wr_data)));

    p_cal_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel) |=> (cal_reg == $past(wr_data)));
endmodule

bind fwr_receiver fwr_receiver_chk #(.WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_reg(ctrl_reg),
    .cal_reg (cal_reg),
    .wr_stb  (wr_stb),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .sel_err (sel_err)
);

// File: tb/fwr_receiver_tb.sv
module fwr_receiver_tb;
    localparam int W        = 24;
    localparam int HALF     = 4;
    localparam int WDOG_MAX = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0, sdata = 1'b0, tfs_n = 1'b1, a0 = 1'b0;
    logic [W-1:0] ctrl_reg, cal_reg, wr_data;
    logic         wr_stb, wr_sel, sel_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int stb_cnt = 0;
    int wide_cnt = 0;
    logic         prev_stb = 1'b0;
    logic [W-1:0] last_data = '0;
    logic         last_sel = 1'b0;
    logic [W-1:0] exp_ctrl = '0, exp_cal = '0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    fwr_receiver #(.WORD_W(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .tfs_n(tfs_n), .a0(a0),
        .ctrl_reg(ctrl_reg), .cal_reg(cal_reg), .wr_stb(wr_stb), .wr_sel(wr_sel),
        .wr_data(wr_data), .sel_err(sel_err)
    );

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            stb_cnt++;
            last_data = wr_data;
            last_sel  = wr_sel;
            if (prev_stb) wide_cnt++;
        end
        prev_stb = wr_stb;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        sdata = b;
        idle(HALF);
        sclk = 1'b1;
        idle(HALF);
        sclk = 1'b0;
    endtask

    // send bits [hi .. hi-n+1] of w; pause (with ignored pulses) before bit index pause_at
    task automatic send(input logic [W-1:0] w, input logic sel, input int hi,
                        input int n, input int pause_at);
        a0 = sel;
        idle(2);
        tfs_n = 1'b0;
        idle(2);
        for (int i = 0; i < n; i++) begin
            if (pause_at > 0 && i == pause_at) begin
                tfs_n = 1'b1;
                idle(3);
                for (int j = 0; j < 3; j++) pulse(1'b1);
                idle(3);
                tfs_n = 1'b0;
                idle(2);
            end
            pulse(w[hi - i]);
        end
        idle(2);
        tfs_n = 1'b1;
        idle(8);
    endtask

    task automatic check_word(input logic [W-1:0] w, input logic sel, input int s0,
                              input string req);
        if (sel) exp_cal = w; else exp_ctrl = w;
        chk(stb_cnt == s0 + 1, "R9", {req, " one strobe"}, W'(stb_cnt - s0), W'(1));
        chk(last_data == w, "R2", {req, " word"}, last_data, w);
        chk(last_sel == sel, "R9", {req, " select"}, W'(last_sel), W'(sel));
        chk(ctrl_reg == exp_ctrl, "R3", {req, " ctrl_reg"}, ctrl_reg, exp_ctrl);
        chk(cal_reg == exp_cal, "R4", {req, " cal_reg"}, cal_reg, exp_cal);
    endtask

    initial begin : wdog
        while (cycles < WDOG_MAX && !done) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WDOG_MAX);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int s0;
        logic [W-1:0] w;
        idle(3);
        // R1 reset state
        chk(ctrl_reg == '0, "R1", "ctrl_reg at reset", ctrl_reg, '0);
        chk(cal_reg == '0, "R1", "cal_reg at reset", cal_reg, '0);
        chk(wr_stb == 1'b0, "R1", "strobe at reset", W'(wr_stb), '0);
        chk(sel_err == 1'b0, "R1", "sel_err at reset", W'(sel_err), '0);
        rst_n = 1'b1;
        idle(4);

        // R5: pulses with the sync released capture nothing
        for (int i = 0; i < 5; i++) pulse(1'b1);
        idle(6);
        chk(stb_cnt == 0, "R5", "no strobe from unframed pulses", W'(stb_cnt), '0);

        // R2/R3/R4/R9: walking one to control, walking zero with pause to calibration (R6)
        for (int k = 0; k < W; k++) begin
            w  = W'(1) << k;
            s0 = stb_cnt;
            send(w, 1'b0, W - 1, W, 0);
            check_word(w, 1'b0, s0, "R3 walk");
            w  = ~(W'(1) << k);
            s0 = stb_cnt;
            send(w, 1'b1, W - 1, W, k);
            check_word(w, 1'b1, s0, "R6 pause");
        end

        // R7: short word does not commit, then completes
        w  = 24'hC3A55A;
        s0 = stb_cnt;
        send(w, 1'b0, W - 1, W - 1, 0);
        chk(stb_cnt == s0, "R7", "no strobe on 23 bits", W'(stb_cnt - s0), '0);
        chk(ctrl_reg == exp_ctrl, "R7", "ctrl_reg unchanged", ctrl_reg, exp_ctrl);
        chk(cal_reg == exp_cal, "R7", "cal_reg unchanged", cal_reg, exp_cal);
        send(w, 1'b0, 0, 1, 0);
        check_word(w, 1'b0, s0, "R7 resumed");

        // R8/R10: select change mid-word aborts
        chk(sel_err == 1'b0, "R10", "sel_err clear before abort", W'(sel_err), '0);
        w  = 24'h123456;
        s0 = stb_cnt;
        a0 = 1'b0;
        idle(2);
        tfs_n = 1'b0;
        idle(2);
        for (int i = 0; i < 10; i++) pulse(w[W - 1 - i]);
        a0 = 1'b1;
        idle(10);
        chk(sel_err == 1'b1, "R8", "sel_err after select change", W'(sel_err), W'(1));
        chk(stb_cnt == s0, "R8", "no strobe after abort", W'(stb_cnt - s0), '0);
        tfs_n = 1'b1;
        idle(4);
        w  = 24'hFEDCBA;
        send(w, 1'b1, W - 1, W, 0);
        check_word(w, 1'b1, s0, "R8 recovery");
        chk(sel_err == 1'b1, "R10", "sel_err sticky", W'(sel_err), W'(1));

        chk(wide_cnt == 0, "R9", "strobe width one cycle", W'(wide_cnt), '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule